// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind a two-wire serial slave and turns a write command into array writes. When the slave has received a word address, the block keeps the upper address bits for the whole command and loads the low bits into a slot pointer. Each complete data byte goes into a small page latch at the slot the pointer names. The pointer then advances and wraps inside the page. A per-slot valid mask records which slots the current command has filled.

Nothing reaches the array until the slave reports a STOP. The block then enters a self-timed write interval and raises `busy`, which the slave uses to refuse polling attempts. During the interval it walks the slots in ascending order, one per clock, and issues an array write for every filled slot. The interval length is a parameter counted in system clocks, so a short value can stand in for the real cell programming time.

Write protection follows a window rule. The protect pin is ignored until the clock that samples the last bit of the first data byte. From that clock until the interval ends, a high protect pin cancels the command or cuts the interval short at once. A low-supply flag blocks commits and aborts a running interval in the same way.

Top module: `page_write_seq`

## Requirements
- R1: An `addrLoad` pulse starts a write command. The upper ADDR_W-PAGE_W address bits are held for the whole command and appear unchanged on `memAddr` while `busy` is high. The low PAGE_W bits set the slot pointer, and the valid mask is cleared.
- R2: Each `byteStb` stores `byteIn` in the slot named by the pointer, marks that slot filled, and advances the pointer by one modulo 2^PAGE_W (16 slots by default).
- R3: When more than 16 bytes arrive before the STOP, the pointer rolls over. A later byte replaces the earlier one in the same slot, and each slot is written to the array at most once.
- R4: The array is written only after a `stopStb` ends a command holding at least one byte. A `startStb` before the STOP drops the command, and a STOP after zero bytes starts no interval (`busy` stays low).
- R5: `busy` rises in the cycle after the STOP cycle and stays high for exactly WR_CYCLES clocks (with WR_CYCLES at least 16). In busy cycle k (counting from 0), slot k is written with `memAddr` low bits equal to k, if and only if that slot was filled.
- R6: `wpPin` has no effect from the address load up to, but not including, the cycle of the first `d0Stb` of the command.
- R7: `wpPin` high in the cycle of the first `d0Stb`, or in any later cycle up to and including the STOP cycle, cancels the command. No interval follows.
- R8: `wpPin` high during the interval drops `memWe` in that same cycle and lowers `busy` at the next edge. No further slots are written.
- R9: `supplyLow` high in the STOP cycle prevents the interval. `supplyLow` high during the interval acts like R8.
- R10: While `busy` is high, `addrLoad`, `byteStb`, `d0Stb`, `startStb` and `stopStb` are ignored. The interval length, the written slots and the held upper address do not change.
- R11: A `byteStb` in the same cycle as `stopStb` is stored and included in the commit.
- R12: During reset `busy` and `memWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Word address of the write command |
| addrLoad | input | 1 | One-cycle pulse: word address received |
| byteIn | input | DATA_W | Received data byte |
| byteStb | input | 1 | One-cycle pulse: data byte complete |
| d0Stb | input | 1 | One-cycle pulse: last bit of a data byte sampled |
| startStb | input | 1 | One-cycle pulse: START condition seen |
| stopStb | input | 1 | One-cycle pulse: STOP condition seen |
| wpPin | input | 1 | Write-protect level, high protects |
| supplyLow | input | 1 | Low-supply indication, high inhibits writes |
| memWe | output | 1 | Array write enable |
| memAddr | output | ADDR_W | Array write address |
| memData | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write interval in progress |

## Verification
Two pairs of events can fall in the same clock. One pair is the closing data byte and the STOP. The other is the first last-bit strobe and a rising protect pin. The bench drives `byteStb` and `stopStb` in one cycle and expects that byte to be written. It also raises `wpPin` only in the cycle of the first `d0Stb` and expects no interval and no writes. Both are judged by counting array writes, comparing the captured slot contents against an arithmetic model of the page, and measuring how many cycles `busy` is high.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Sequencer states: waiting, gathering bytes of a command, timed commit.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_WRITE   = 2'd2
  } seqState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadAddr;   // capture address, clear slot mask
    logic storeByte;  // write byteIn into pointed slot
    logic scanOn;     // current scan slot may reach the array
  } dpCmd_t;

endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter int CYC    = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic              byteStb,
  input  logic              d0Stb,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              wpPin,
  input  logic              supplyLow,
  input  logic              anyValid,
  output dpCmd_t            cmd,
  output logic [PAGE_W-1:0] scanIdx,
  output logic              busy
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TW         = $clog2(CYC + 1);

  seqState_t     state, stateNext;
  logic          firstSeen;
  logic [TW-1:0] timer;

  logic inWindow, wpCancel, commitOk, loadNow, lastTick, inScan;

  // Protect window opens at the first last-bit strobe and stays open.
  assign inWindow = firstSeen | d0Stb;
  assign wpCancel = (state == ST_COLLECT) && inWindow && wpPin;
  assign commitOk = (anyValid || byteStb) && !supplyLow;
  assign loadNow  = (state != ST_WRITE) && addrLoad && !wpCancel;
  assign lastTick = (timer == TW'(CYC - 1));
  assign inScan   = (timer < TW'(PAGE_BYTES));

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (addrLoad) stateNext = ST_COLLECT;
      end
      ST_COLLECT: begin
        if (wpCancel)      stateNext = ST_IDLE;
        else if (addrLoad) stateNext = ST_COLLECT;
        else if (stopStb)  stateNext = commitOk ? ST_WRITE : ST_IDLE;
        else if (startStb) stateNext = ST_IDLE;
      end
      ST_WRITE: begin
        if (wpPin || supplyLow) stateNext = ST_IDLE;
        else if (lastTick)      stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd.loadAddr  = loadNow;
    cmd.storeByte = (state == ST_COLLECT) && byteStb && !wpCancel && !addrLoad;
    cmd.scanOn    = (state == ST_WRITE) && inScan && !wpPin && !supplyLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      firstSeen <= 1'b0;
      timer     <= '0;
    end else begin
      state     <= stateNext;
      firstSeen <= (stateNext == ST_COLLECT) && !loadNow &&
                   (firstSeen || ((state == ST_COLLECT) && d0Stb));
      if (state == ST_WRITE) timer <= timer + 1'b1;
      else                   timer <= '0;
    end
  end

  assign scanIdx = timer[PAGE_W-1:0];
  assign busy    = (state == ST_WRITE);

endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] byteIn,
  input  logic [PAGE_W-1:0] scanIdx,
  output logic              anyValid,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - PAGE_W;

  logic [HI_W-1:0]       hiAddr;
  logic [PAGE_W-1:0]     ptr;
  logic [DATA_W-1:0]     slotData [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slotValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiAddr <= '0;
      ptr    <= '0;
    end else if (cmd.loadAddr) begin
      hiAddr <= addrIn[ADDR_W-1:PAGE_W];
      ptr    <= addrIn[PAGE_W-1:0];
    end else if (cmd.storeByte) begin
      ptr    <= ptr + 1'b1;  // wraps inside the page
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : gSlot
    logic [DATA_W-1:0] q;
    logic              v;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= '1;
        v <= 1'b0;
      end else if (cmd.loadAddr) begin
        v <= 1'b0;
      end else if (cmd.storeByte && (ptr == PAGE_W'(i))) begin
        q <= byteIn;
        v <= 1'b1;
      end
    end
    assign slotData[i]  = q;
    assign slotValid[i] = v;
  end

  assign anyValid = |slotValid;
  assign memWe    = cmd.scanOn && slotValid[scanIdx];
  assign memAddr  = {hiAddr, scanIdx};
  assign memData  = slotData[scanIdx];

endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pgw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              addrLoad,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              byteStb,
  input  logic              d0Stb,
  input  logic              startStb,
  input  logic              stopStb,
  input  logic              wpPin,
  input  logic              supplyLow,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              busy
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CYC = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;

  dpCmd_t            cmd;
  logic [PAGE_W-1:0] scanIdx;
  logic              anyValid;

  pgw_ctrl #(.PAGE_W(PAGE_W), .CYC(CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .byteStb(byteStb),
    .d0Stb(d0Stb), .startStb(startStb), .stopStb(stopStb),
    .wpPin(wpPin), .supplyLow(supplyLow), .anyValid(anyValid),
    .cmd(cmd), .scanIdx(scanIdx), .busy(busy)
  );

  pgw_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .addrIn(addrIn), .byteIn(byteIn),
    .scanIdx(scanIdx), .anyValid(anyValid), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopStb,
  input logic              wpPin,
  input logic              supplyLow,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy
);

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CYC = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES;
  localparam int CW  = $clog2(CYC + 2);

  logic [CW-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R5
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopStb)); // R4
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < CW'(CYC))); // R5
  AST_WP_GATES_WE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !wpPin); // R8
  AST_WP_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wpPin) |=> !busy); // R8
  AST_LOW_ABORTS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && supplyLow) |=> !busy); // R9
  AST_LOW_GATES_WE: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !supplyLow); // R9
  AST_STOP_WP_CANCEL: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && wpPin && !busy) |=> !busy); // R7
  AST_HI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr[ADDR_W-1:PAGE_W])); // R10

endmodule

bind page_write_seq pgw_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .stopStb(stopStb), .wpPin(wpPin),
  .supplyLow(supplyLow), .memWe(memWe), .memAddr(memAddr), .busy(busy)
);

// File: tb/sim_page_write_seq.sv
module sim_page_write_seq;
  localparam int AW = 10, PW = 4, DW = 8, WC = 24, PB = 16;

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] addrIn = '0;
  logic [DW-1:0] byteIn = '0;
  logic addrLoad = 0, byteStb = 0, d0Stb = 0, startStb = 0, stopStb = 0;
  logic wpPin = 0, supplyLow = 0;
  logic memWe, busy;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;

  page_write_seq #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(DW), .WR_CYCLES(WC)) u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrLoad(addrLoad),
    .byteIn(byteIn), .byteStb(byteStb), .d0Stb(d0Stb), .startStb(startStb),
    .stopStb(stopStb), .wpPin(wpPin), .supplyLow(supplyLow),
    .memWe(memWe), .memAddr(memAddr), .memData(memData), .busy(busy)
  );

  int nChecks = 0, nFail = 0;
  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Capture of array writes, sampled at the falling edge.
  logic [DW-1:0] capData [PB];
  bit            capMask [PB];
  logic [DW-1:0] expData [PB];
  bit            expMask [PB];
  int wrCount, busyIdx, busyLen, orderBad, hiBad;
  logic [AW-PW-1:0] expHi;

  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) begin
        wrCount++;
        if (int'(memAddr[PW-1:0]) != busyIdx) orderBad++;
        if (memAddr[AW-1:PW] != expHi) hiBad++;
        capMask[memAddr[PW-1:0]] = 1'b1;
        capData[memAddr[PW-1:0]] = memData;
      end
      if (busy) begin busyIdx++; busyLen++; end
      else busyIdx = 0;
    end
  end

  task automatic clearCap(int hi);
    for (int i = 0; i < PB; i++) begin
      capMask[i] = 0; expMask[i] = 0; capData[i] = '0; expData[i] = '0;
    end
    wrCount = 0; busyLen = 0; orderBad = 0; hiBad = 0;
    expHi = (AW-PW)'(hi);
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sendAddr(int hi, int lo);
    addrIn = {(AW-PW)'(hi), PW'(lo)}; addrLoad = 1; cyc(1); addrLoad = 0;
  endtask

  task automatic sendByte(logic [DW-1:0] d, bit wpAtD0);
    d0Stb = 1; if (wpAtD0) wpPin = 1; cyc(1);
    d0Stb = 0; if (wpAtD0) wpPin = 0;
    byteIn = d; byteStb = 1; cyc(1); byteStb = 0;
  endtask

  task automatic sendStop();
    stopStb = 1; cyc(1); stopStb = 0;
  endtask

  task automatic settle();
    cyc(WC + 4);
  endtask

  function automatic logic [DW-1:0] dataOf(int s, int n, int k);
    return DW'(s * 16 + n * 7 + k * 13 + 1);
  endfunction

  function automatic bit pageMatches();
    for (int i = 0; i < PB; i++) begin
      if (capMask[i] != expMask[i]) return 0;
      if (expMask[i] && capData[i] != expData[i]) return 0;
    end
    return 1;
  endfunction

  task automatic judge(string req, int expWr, int expLen);
    check(pageMatches(), req, "page contents match model", 0, 1);
    check(wrCount == expWr, req, "array write count", wrCount, expWr);
    check(busyLen == expLen, req, "busy cycles", busyLen, expLen);
    check(orderBad == 0 && hiBad == 0, req, "slot order and upper bits",
          orderBad + hiBad, 0);
  endtask

  task automatic runPage(int s, int n);
    int hi = (s * 5 + n) % 64;
    int filled = 0;
    clearCap(hi);
    sendAddr(hi, s);
    for (int k = 0; k < n; k++) begin
      int slot = (s + k) % PB;
      sendByte(dataOf(s, n, k), 0);
      if (!expMask[slot]) filled++;
      expMask[slot] = 1; expData[slot] = dataOf(s, n, k);
    end
    sendStop();
    settle();
    // R1 R2 R3 R5 through the sweep, R4 for n == 0
    judge(n == 0 ? "R4" : (n > PB ? "R3" : "R2"), filled, n == 0 ? 0 : WC);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(10 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    finishRun();
  end

  initial begin
    #12;
    check(busy == 0, "R12", "busy in reset", int'(busy), 0);
    check(memWe == 0, "R12", "memWe in reset", int'(memWe), 0);
    @(posedge clk); #1; rstN = 1; cyc(2);

    // Sweep: every start slot with 0..20 bytes (R1, R2, R3, R4, R5).
    for (int s = 0; s < PB; s++)
      for (int n = 0; n <= 20; n++) runPage(s, n);

    // R4: START before STOP drops the command.
    clearCap(3); sendAddr(3, 2);
    for (int k = 0; k < 3; k++) sendByte(dataOf(2, 3, k), 0);
    startStb = 1; cyc(1); startStb = 0; sendStop(); settle();
    judge("R4", 0, 0);

    // R6: protect high before the first last-bit strobe is ignored.
    clearCap(7); wpPin = 1; sendAddr(7, 4); cyc(2); wpPin = 0;
    for (int k = 0; k < 3; k++) begin
      sendByte(dataOf(4, 3, k), 0); expMask[4 + k] = 1; expData[4 + k] = dataOf(4, 3, k);
    end
    sendStop(); settle();
    judge("R6", 3, WC);

    // R7: protect high exactly with the first last-bit strobe.
    clearCap(8); sendAddr(8, 0);
    sendByte(8'h11, 1); sendByte(8'h22, 0); sendStop(); settle();
    judge("R7", 0, 0);

    // R7: protect pulse between bytes.
    clearCap(9); sendAddr(9, 0); sendByte(8'h33, 0);
    wpPin = 1; cyc(1); wpPin = 0;
    sendByte(8'h44, 0); sendStop(); settle();
    judge("R7", 0, 0);

    // R7: protect high in the STOP cycle.
    clearCap(10); sendAddr(10, 0); sendByte(8'h55, 0);
    wpPin = 1; sendStop(); wpPin = 0; settle();
    judge("R7", 0, 0);

    // R8: protect rises in busy cycle 5 of an 8-byte commit.
    clearCap(5); sendAddr(5, 0);
    for (int k = 0; k < 8; k++) begin
      sendByte(dataOf(0, 8, k), 0);
      if (k < 5) begin expMask[k] = 1; expData[k] = dataOf(0, 8, k); end
    end
    sendStop(); cyc(5); wpPin = 1; cyc(1); wpPin = 0; settle();
    judge("R8", 5, 6);

    // R9: supply low in the STOP cycle.
    clearCap(11); sendAddr(11, 0); sendByte(8'h66, 0);
    supplyLow = 1; sendStop(); supplyLow = 0; settle();
    judge("R9", 0, 0);

    // R9: supply low in busy cycle 3.
    clearCap(12); sendAddr(12, 0);
    for (int k = 0; k < 6; k++) begin
      sendByte(dataOf(1, 6, k), 0);
      if (k < 3) begin expMask[k] = 1; expData[k] = dataOf(1, 6, k); end
    end
    sendStop(); cyc(3); supplyLow = 1; cyc(1); supplyLow = 0; settle();
    judge("R9", 3, 4);

    // R10: a whole second command issued while busy has no effect.
    clearCap(13); sendAddr(13, 6);
    for (int k = 0; k < 4; k++) begin
      sendByte(dataOf(6, 4, k), 0); expMask[6 + k] = 1; expData[6 + k] = dataOf(6, 4, k);
    end
    sendStop(); cyc(1);
    sendAddr(40, 0); sendByte(8'hA5, 0); sendByte(8'h5A, 0);
    startStb = 1; cyc(1); startStb = 0; sendStop();
    settle(); settle();
    judge("R10", 4, WC);

    // R11: last byte strobe coincides with STOP.
    clearCap(9); sendAddr(9, 14);
    d0Stb = 1; cyc(1); d0Stb = 0;
    byteIn = 8'h5A; byteStb = 1; stopStb = 1; cyc(1); byteStb = 0; stopStb = 0;
    expMask[14] = 1; expData[14] = 8'h5A;
    settle();
    judge("R11", 1, WC);

    finishRun();
  end
endmodule